// File: doc/BRIEF.md
# Serial Page-Buffer Command Front End

This block is the slave-side command interface of a page-organised flash memory. A host holds chip select low and clocks in, most significant bit first, an 8-bit opcode followed by a 24-bit address field. The front end recognises four array commands: buffered page program, page-to-buffer transfer, page-to-buffer compare and auto page rewrite. For a buffered page program it also takes the data bytes that follow the address field and stores them in a page buffer. The buffer write position starts at an offset given in the command and wraps inside the buffer, whose depth of 264 bytes is not a power of two.

Nothing is started while the frame is still being clocked in. When chip select is released, a valid command produces a single-cycle launch pulse that carries the opcode and the page number to the array sequencer. The sequencer reports back a busy level and a compare result. While it is busy, the front end refuses every command except the status read. The serial pins are asynchronous to the system clock. They are synchronised, and the block acts on the rising edges of the serial clock that it detects in the system clock domain.

Top module: `sflash_cmd_front`

## Requirements
- R1: A frame is 8 opcode bits followed by 24 address bits, all MSB first, sampled on rising serial-clock edges while `csn_i` is low. Of the 24-bit field, bits 23:18 are reserved, bits 17:9 are the page number (0..511) and bits 8:0 are the buffer byte offset.
- R2: Opcodes 0x82 (buffered program), 0x53 (page to buffer), 0x60 (compare) and 0x58 (auto rewrite) each produce a launch with `launch_op_o` equal to the opcode and `launch_page_o` equal to the page number of the frame.
- R3: A launch happens only after `csn_i` goes from low to high. No launch is raised while chip select is still low. `launch_o` is high for exactly one system clock per accepted frame.
- R4: For opcode 0x82, each complete data byte after the 32 command bits is written to the buffer at the current position, which then advances by one. The first position is the offset; an offset of 264 or more starts at offset minus 264.
- R5: After writing offset 263, the position returns to 0, and later bytes overwrite the earlier ones.
- R6: A frame that ends before 32 command bits, or that carries an opcode other than 0x82, 0x53, 0x60, 0x58 or 0x57, produces no launch and writes nothing.
- R7: A data byte that is still incomplete when chip select rises is discarded. The complete bytes before it are kept, and the launch still takes place.
- R8: If `seq_busy_i` is high when the eighth opcode bit arrives, a frame with any opcode other than 0x57 is ignored: there is no launch and no buffer write.
- R9: Opcode 0x57 is accepted even when busy. From the next serial bit on, `miso_o` shifts out a status byte, MSB first and repeating every 8 bits. The byte is captured as the opcode completes: bit 7 = `seq_busy_i`, bit 6 = `cmp_equal_i`, bits 5:0 = 0.
- R10: After reset, `launch_o` and `miso_o` are low. Outside a status read, `miso_o` stays low.
- R11: `buf_rd_data_o` returns the buffer byte at `buf_rd_addr_i` one system clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from host (asynchronous) |
| csn_i | input | 1 | Active-low chip select from host |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial status data to host |
| seq_busy_i | input | 1 | Array sequencer busy |
| cmp_equal_i | input | 1 | Result of last compare, 1 = equal |
| buf_rd_addr_i | input | 9 | Buffer read offset from the sequencer |
| buf_rd_data_o | output | 8 | Buffer byte, one clock after the address |
| launch_o | output | 1 | Single-cycle command launch |
| launch_op_o | output | 8 | Opcode of the launched command |
| launch_page_o | output | 9 | Page number of the launched command |

## Verification
A wrong bit count or a wrong field split shows up on the launch outputs a few system clocks after chip select is released, as a wrong opcode or page, a missing pulse, or an extra one. A pointer fault, such as a wrong start offset, a wrap taken at the wrong place or a partial byte committed, shows up at the buffer read port. Those bytes are observable one clock after they are addressed, so the whole buffer is read back against a model after every data phase. An error in the status path appears on the serial output within the bit that follows the status opcode.

// File: rtl/sfcf_pkg.sv
package sfcf_pkg;

    localparam int OP_W    = 8;
    localparam int FIELD_W = 24;
    localparam int HDR_W   = OP_W + FIELD_W;
    localparam int PAGE_W  = 9;
    localparam int OFS_W   = 9;
    localparam int BYTE_W  = 8;
    localparam int HCNT_W  = $clog2(HDR_W + 1);
    localparam int DCNT_W  = $clog2(BYTE_W);

    localparam logic [OP_W-1:0] OP_PROG_BUF = 8'h82;
    localparam logic [OP_W-1:0] OP_PG2BUF   = 8'h53;
    localparam logic [OP_W-1:0] OP_COMPARE  = 8'h60;
    localparam logic [OP_W-1:0] OP_REWRITE  = 8'h58;
    localparam logic [OP_W-1:0] OP_STATUS   = 8'h57;

    typedef enum logic [2:0] {
        FS_HDR,
        FS_DATA,
        FS_HOLD,
        FS_STAT,
        FS_DROP
    } frame_state_e;

    typedef struct packed {
        frame_state_e          st;
        logic [HDR_W-1:0]      hdr;
        logic [HCNT_W-1:0]     hcnt;
        logic [BYTE_W-1:0]     dsh;
        logic [DCNT_W-1:0]     dcnt;
        logic [OFS_W-1:0]      ptr;
        logic [BYTE_W-1:0]     stat;
        logic                  lvld;
        logic [OP_W-1:0]       lop;
        logic [PAGE_W-1:0]     lpage;
    } dec_state_t;

    typedef struct packed {
        logic sck_prev;
        logic cs_prev;
    } edge_state_t;

    function automatic logic is_array_cmd(input logic [OP_W-1:0] op);
        return (op == OP_PROG_BUF) || (op == OP_PG2BUF) ||
               (op == OP_COMPARE)  || (op == OP_REWRITE);
    endfunction

endpackage

// File: rtl/sfcf_sync.sv
module sfcf_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/sfcf_edges.sv
module sfcf_edges
    import sfcf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic csn_raw,
    input  logic mosi_raw,
    output logic sck_rise,
    output logic cs_rise,
    output logic cs_high,
    output logic mosi_s
);

    logic [2:0]  sync_out;
    logic        sck_s;
    logic        csn_s;
    edge_state_t e_d, e_q;

    sfcf_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck_raw, csn_raw, mosi_raw}),
        .dout  (sync_out)
    );

    assign sck_s  = sync_out[2];
    assign csn_s  = sync_out[1];
    assign mosi_s = sync_out[0];

    always_comb begin
        e_d          = e_q;
        e_d.sck_prev = sck_s;
        e_d.cs_prev  = csn_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{sck_prev: 1'b0, cs_prev: 1'b1};
        else        e_q <= e_d;
    end

    assign sck_rise = sck_s & ~e_q.sck_prev;
    assign cs_rise  = csn_s & ~e_q.cs_prev;
    assign cs_high  = csn_s;

endmodule

// File: rtl/sfcf_page_buffer.sv
module sfcf_page_buffer #(
    parameter int DEPTH = 264,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < DEPTH_A)) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_d = '0;
        if (rd_addr < DEPTH_A) rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R4: the decoder never aims a write outside the buffer
    p_wr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < DEPTH_A));

endmodule

// File: rtl/sfcf_decoder.sv
module sfcf_decoder
    import sfcf_pkg::*;
#(
    parameter int BUF_DEPTH = 264
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              cs_rise,
    input  logic              cs_high,
    input  logic              mosi,
    input  logic              seq_busy,
    input  logic              cmp_equal,
    output logic              wr_en,
    output logic [OFS_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              miso,
    output logic              launch,
    output logic [OP_W-1:0]   launch_op,
    output logic [PAGE_W-1:0] launch_page
);

    localparam logic [OFS_W-1:0]  DEPTH_O   = OFS_W'(BUF_DEPTH);
    localparam logic [OFS_W-1:0]  LAST_O    = OFS_W'(BUF_DEPTH - 1);
    localparam logic [HCNT_W-1:0] OP_DONE   = HCNT_W'(OP_W - 1);
    localparam logic [HCNT_W-1:0] HDR_DONE  = HCNT_W'(HDR_W - 1);
    localparam logic [DCNT_W-1:0] BYTE_DONE = DCNT_W'(BYTE_W - 1);

    dec_state_t       s_d, s_q;
    logic [HDR_W-1:0] hdr_next;
    logic [OFS_W-1:0] ofs_field;

    function automatic logic [OFS_W-1:0] fold_ofs(input logic [OFS_W-1:0] o);
        return (o >= DEPTH_O) ? (o - DEPTH_O) : o;
    endfunction

    function automatic logic [OFS_W-1:0] step_ofs(input logic [OFS_W-1:0] o);
        return (o == LAST_O) ? '0 : (o + 1'b1);
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.lvld  = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = s_q.ptr;
        wr_data   = {s_q.dsh[BYTE_W-2:0], mosi};
        hdr_next  = {s_q.hdr[HDR_W-2:0], mosi};
        ofs_field = hdr_next[OFS_W-1:0];

        if (cs_high) begin
            if (cs_rise && ((s_q.st == FS_DATA) || (s_q.st == FS_HOLD))) begin
                s_d.lvld  = 1'b1;
                s_d.lop   = s_q.hdr[HDR_W-1 -: OP_W];
                s_d.lpage = s_q.hdr[OFS_W +: PAGE_W];
            end
            s_d.st   = FS_HDR;
            s_d.hcnt = '0;
            s_d.dcnt = '0;
        end else if (sck_rise) begin
            unique case (s_q.st)
                FS_HDR: begin
                    s_d.hdr  = hdr_next;
                    s_d.hcnt = s_q.hcnt + 1'b1;
                    if (s_q.hcnt == OP_DONE) begin
                        if (hdr_next[OP_W-1:0] == OP_STATUS) begin
                            s_d.st   = FS_STAT;
                            s_d.stat = {seq_busy, cmp_equal, 6'b0};
                        end else if (seq_busy || !is_array_cmd(hdr_next[OP_W-1:0])) begin
                            s_d.st = FS_DROP;
                        end
                    end
                    if (s_q.hcnt == HDR_DONE) begin
                        s_d.st   = (hdr_next[HDR_W-1 -: OP_W] == OP_PROG_BUF) ? FS_DATA : FS_HOLD;
                        s_d.ptr  = fold_ofs(ofs_field);
                        s_d.dcnt = '0;
                    end
                end
                FS_DATA: begin
                    s_d.dsh  = wr_data;
                    s_d.dcnt = s_q.dcnt + 1'b1;
                    if (s_q.dcnt == BYTE_DONE) begin
                        wr_en   = 1'b1;
                        s_d.ptr = step_ofs(s_q.ptr);
                    end
                end
                FS_STAT: begin
                    s_d.stat = {s_q.stat[BYTE_W-2:0], s_q.stat[BYTE_W-1]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= FS_HDR;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso        = (s_q.st == FS_STAT) ? s_q.stat[BYTE_W-1] : 1'b0;
    assign launch      = s_q.lvld;
    assign launch_op   = s_q.lop;
    assign launch_page = s_q.lpage;

    // R3: a launch never lasts more than one clock
    p_launch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    // R2: only the four array commands ever reach the sequencer
    p_launch_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> is_array_cmd(launch_op));

    // R8: a refused frame never touches the buffer
    p_drop_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == FS_DROP) |-> !wr_en);

    // R5: the write position stays inside the buffer
    p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ptr < DEPTH_O);

    // R9: the status bit on the serial output changes only on a serial clock edge
    p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == FS_STAT) && !sck_rise && !cs_high) |=> $stable(miso));

    // R10: the serial output is quiet outside a status read
    p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != FS_STAT) |-> !miso);

endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
    import sfcf_pkg::*;
#(
    parameter int BUF_DEPTH   = 264,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              seq_busy_i,
    input  logic              cmp_equal_i,
    input  logic [OFS_W-1:0]  buf_rd_addr_i,
    output logic [BYTE_W-1:0] buf_rd_data_o,
    output logic              launch_o,
    output logic [OP_W-1:0]   launch_op_o,
    output logic [PAGE_W-1:0] launch_page_o
);

    logic              sck_rise;
    logic              cs_rise;
    logic              cs_high;
    logic              mosi_s;
    logic              wr_en;
    logic [OFS_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;

    sfcf_edges #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_raw  (sck_i),
        .csn_raw  (csn_i),
        .mosi_raw (mosi_i),
        .sck_rise (sck_rise),
        .cs_rise  (cs_rise),
        .cs_high  (cs_high),
        .mosi_s   (mosi_s)
    );

    sfcf_decoder #(
        .BUF_DEPTH (BUF_DEPTH)
    ) i_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_rise    (sck_rise),
        .cs_rise     (cs_rise),
        .cs_high     (cs_high),
        .mosi        (mosi_s),
        .seq_busy    (seq_busy_i),
        .cmp_equal   (cmp_equal_i),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .miso        (miso_o),
        .launch      (launch_o),
        .launch_op   (launch_op_o),
        .launch_page (launch_page_o)
    );

    sfcf_page_buffer #(
        .DEPTH (BUF_DEPTH),
        .AW    (OFS_W),
        .DW    (BYTE_W)
    ) i_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (buf_rd_addr_i),
        .rd_data (buf_rd_data_o)
    );

endmodule

// File: tb/test_sflash_cmd_front.sv
module test_sflash_cmd_front;

    localparam int DEPTH = 264;
    localparam int HALF  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       csn = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic       busy = 1'b0;
    logic       cmp_eq = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       launch;
    logic [7:0] l_op;
    logic [8:0] l_page;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int         lcount = 0;
    int         run = 0;
    int         maxrun = 0;
    logic [7:0] last_op = '0;
    logic [8:0] last_page = '0;
    logic [7:0] exp_buf [DEPTH];

    always #2.5 clk = ~clk;

    sflash_cmd_front i_sflash_cmd_front (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_i         (sck),
        .csn_i         (csn),
        .mosi_i        (mosi),
        .miso_o        (miso),
        .seq_busy_i    (busy),
        .cmp_equal_i   (cmp_eq),
        .buf_rd_addr_i (rd_addr),
        .buf_rd_data_o (rd_data),
        .launch_o      (launch),
        .launch_op_o   (l_op),
        .launch_page_o (l_page)
    );

    always @(posedge clk) begin
        if (rst_n && launch) begin
            lcount    <= lcount + 1;
            last_op   <= l_op;
            last_page <= l_page;
            run       <= run + 1;
            if (run + 1 > maxrun) maxrun <= run + 1;
        end else begin
            run <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        mosi = b;
        tick(HALF);
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic begin_frame();
        csn = 1'b0;
        tick(HALF);
    endtask

    task automatic end_frame();
        tick(HALF);
        csn = 1'b1;
        tick(12);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [8:0] pg, input logic [8:0] ofs);
        logic [23:0] f;
        f = {6'b0, pg, ofs};
        send_byte(op);
        for (int i = 23; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_addr = 9'(a);
        tick(1);
        v = rd_data;
    endtask

    task automatic check_buffer(input string req);
        logic [7:0] v;
        int bad;
        bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            if (v !== exp_buf[a] && bad < 4) begin
                chk(0, req, int'(v), int'(exp_buf[a]));
                bad++;
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic prog(input logic [8:0] ofs, input int n, input int seed);
        int p;
        logic [7:0] b;
        p = (ofs >= 9'(DEPTH)) ? int'(ofs) - DEPTH : int'(ofs);
        begin_frame();
        send_hdr(8'h82, 9'h011, ofs);
        for (int i = 0; i < n; i++) begin
            b = 8'((i * 13 + seed) & 255);
            send_byte(b);
            exp_buf[p] = b;
            p = (p == DEPTH - 1) ? 0 : p + 1;
        end
        end_frame();
    endtask

    function automatic bit known(input logic [7:0] op);
        return op == 8'h82 || op == 8'h53 || op == 8'h60 || op == 8'h58;
    endfunction

    task automatic read_status(input logic [7:0] expv, input string req);
        logic [15:0] got;
        begin_frame();
        send_byte(8'h57);
        for (int k = 0; k < 16; k++) begin
            mosi = 1'b0;
            tick(HALF);
            got[15-k] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        end_frame();
        chk(got == {expv, expv}, req, int'(got), int'({expv, expv}));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] v;
        logic [8:0] pgs [9];

        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R10: reset state
        chk(launch == 1'b0, "R10 launch after reset", int'(launch), 0);
        chk(miso == 1'b0, "R10 miso after reset", int'(miso), 0);

        // R4 R11: fill the whole buffer from offset 0, read back one clock after address
        prog(9'd0, DEPTH, 3);
        check_buffer("R4 R11 full fill");
        chk(last_op == 8'h82, "R2 program launch op", int'(last_op), 'h82);

        // R5: wrap from near the end
        prog(9'd260, 12, 77);
        check_buffer("R5 wrap at 263");

        // R4: offset 300 folds to 36
        prog(9'd300, 3, 150);
        check_buffer("R4 offset above depth");

        // R7: trailing partial byte discarded
        base = lcount;
        begin_frame();
        send_hdr(8'h82, 9'h044, 9'd10);
        send_byte(8'h5A);
        exp_buf[10] = 8'h5A;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        end_frame();
        check_buffer("R7 partial byte");
        chk(lcount == base + 1, "R7 launch still sent", lcount - base, 1);
        chk(last_page == 9'h044, "R1 page field", int'(last_page), 'h44);

        // R6: frame cut short after 20 bits
        base = lcount;
        begin_frame();
        send_byte(8'h53);
        for (int i = 0; i < 12; i++) send_bit(1'b0);
        end_frame();
        chk(lcount == base, "R6 short frame", lcount - base, 0);

        // R8: busy blocks commands and buffer writes
        busy = 1'b1;
        base = lcount;
        begin_frame();
        send_hdr(8'h53, 9'd3, 9'd0);
        end_frame();
        begin_frame();
        send_hdr(8'h82, 9'd3, 9'd5);
        send_byte(~exp_buf[5]);
        end_frame();
        chk(lcount == base, "R8 busy no launch", lcount - base, 0);
        check_buffer("R8 busy no write");

        // R9: status read with all busy/compare combinations
        cmp_eq = 1'b1;
        read_status(8'hC0, "R9 status busy eq");
        busy = 1'b0;
        read_status(8'h40, "R9 status ready eq");
        cmp_eq = 1'b0;
        read_status(8'h00, "R9 status ready ne");
        busy = 1'b1;
        read_status(8'h80, "R9 status busy ne");
        busy = 1'b0;

        // R3: no launch while chip select is still low
        base = lcount;
        begin_frame();
        send_hdr(8'h60, 9'h1F0, 9'd0);
        tick(20);
        chk(lcount == base, "R3 no launch before release", lcount - base, 0);
        end_frame();
        chk(lcount == base + 1, "R3 launch after release", lcount - base, 1);

        // R1 R2: page sweep for every array command
        pgs[8] = 9'd511;
        for (int i = 0; i < 8; i++) pgs[i] = 9'((i * 73) % 512);
        for (int o = 0; o < 4; o++) begin
            logic [7:0] op;
            op = (o == 0) ? 8'h82 : (o == 1) ? 8'h53 : (o == 2) ? 8'h60 : 8'h58;
            for (int i = 0; i < 9; i++) begin
                base = lcount;
                begin_frame();
                send_hdr(op, pgs[i], 9'h1AB);
                end_frame();
                chk(lcount == base + 1 && last_op == op && last_page == pgs[i],
                    "R1 R2 launch op/page", int'({last_op, last_page}), int'({op, pgs[i]}));
            end
        end

        // R6 R2: sweep all opcodes with complete headers
        for (int op = 0; op < 256; op++) begin
            base = lcount;
            begin_frame();
            send_hdr(8'(op), 9'h0A5, 9'd0);
            end_frame();
            if (known(8'(op)))
                chk(lcount == base + 1 && last_op == 8'(op), "R2 known opcode",
                    int'(last_op), op);
            else
                chk(lcount == base, "R6 unknown opcode", lcount - base, 0);
        end
        check_buffer("R6 sweep leaves buffer");

        chk(maxrun == 1, "R3 pulse width", maxrun, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule